// File: doc/BRIEF.md
# Eight-line priority interrupt controller

The block collects interrupt requests from eight lines, each arriving as a single-cycle pulse, and presents at most one of them to a processor. Each request comes with a vector number. A request is latched only if its line is unmasked when it arrives. A fixed-priority scan picks the line to signal: line 0 is the most important and line 7 the least. A line that is in service blocks every line of lower importance. When the processor acknowledges a vector, the matching line moves from pending to in service. Software later releases that line with an end-of-interrupt command.

Software reaches the block over a byte-wide register bus with a single address bit. Address 0 is the command port and address 1 is the data port. A three-step start-up sequence sets the vector base. After that, data writes set the mask. Command writes issue end-of-interrupt operations and choose which state the command port returns on a read: the pending set or the in-service set. Only one controller is supported, with edge-style (pulse) inputs.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After a synchronous reset, the mask, pending set and in-service set are all zero, and the command port reads back the pending set. The sequencer is idle and `int_req` is low.
- R2: A command write with bit 4 set starts the start-up sequence. The next data write sets the vector base and the one after it ends the sequence. Neither of these two writes changes the mask.
- R3: The vector base takes bits 7:3 of its data write, and bits 2:0 are forced to zero. `int_vec` equals the base plus the signalled line number, and it follows a new base while the request stays pending.
- R4: With the sequencer idle, a data write loads the 8-bit mask (bit n masks line n). A read of address 1 returns the mask.
- R5: A pulse on a masked line is discarded. It is not recorded later when the mask is cleared.
- R6: A pulse on an unmasked line sets its bit in the pending set. A read of address 0 returns the pending set while that readback is selected.
- R7: Line 0 has the highest priority. Of several pending lines, the lowest-numbered one is signalled. `int_req` rises on the second clock edge after the pulse.
- R8: Scanning upward from line 0, if an in-service bit comes before any pending bit, `int_req` stays low. A pending line above all in-service bits is still signalled.
- R9: An acknowledge vector in the range base to base+7 sets that line's in-service bit and clears its pending bit. `int_req` is low at the following cycle. Vectors outside that range change nothing.
- R10: Command value 0x20 (bits 7:5 = 001, bits 4:3 = 00) clears the lowest-numbered in-service bit.
- R11: Command value 0x60 | n (bits 7:5 = 011) clears in-service bit n. Other values with bits 4:3 = 00 change nothing.
- R12: A command write with bit 7 clear and bits 4:3 = 01 selects the readback. Low bits 10 select the pending set and 11 select the in-service set. Other low bits keep the current choice.
- R13: The mask is applied only when a request arrives. A request that is already pending is still signalled after its line is masked.
- R14: Read data appears at the clock edge where `rd_en` is sampled and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 1 | 0 = command port, 1 = data port |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| irq_in | input | 8 | Request pulses, one bit per line |
| ack_valid | input | 1 | Processor acknowledge strobe |
| ack_vec | input | 8 | Vector being acknowledged |
| int_req | output | 1 | Interrupt request to the processor |
| int_vec | output | 8 | Vector of the signalled line |

## Verification
The arbitration is tried with several request patterns, and each one separates a different fault:
- Two lines pending together show whether the lower-numbered line wins.
- A higher-priority pulse that arrives while a lower line is in service shows that nesting works.
- A lower-priority pulse behind an in-service line shows that blocking works.
- A pulse on a masked line, followed by unmasking, separates discarding a request from merely deferring it.
- A request that is pending before its line is masked separates masking at arrival from masking at arbitration.

End-of-interrupt commands are tried with the non-specific form, the specific form and an unused encoding. Acknowledges are tried both inside and outside the vector window.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  typedef enum logic [1:0] {
    INIT_IDLE = 2'd0,
    INIT_BASE = 2'd1,
    INIT_TAIL = 2'd2
  } init_state_t;

  typedef enum logic {
    RB_PEND = 1'b0,
    RB_SVC  = 1'b1
  } readback_t;
endpackage

// File: rtl/irq_cmd_decode.sv
module irq_cmd_decode
  import irq_prio_pkg::*;
#(
  parameter int LINES = 8,
  parameter int DW    = 8,
  localparam int IDXW = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             addr,
  input  logic [DW-1:0]    wr_data,
  input  logic [LINES-1:0] isr,
  output logic [DW-1:0]    mask_q,
  output logic [DW-1:0]    base_q,
  output readback_t        rb_sel_q,
  output logic [LINES-1:0] eoi_clr
);
  init_state_t state_q;

  logic cmd_wr, data_wr, is_init, is_eoi_op, is_sel_op;
  assign cmd_wr    = wr_en && !addr;
  assign data_wr   = wr_en && addr;
  assign is_init   = cmd_wr && wr_data[4];
  assign is_eoi_op = cmd_wr && (wr_data[4:3] == 2'b00);
  assign is_sel_op = cmd_wr && !wr_data[7] && (wr_data[4:3] == 2'b01);

  // lowest set in-service bit, for the non-specific release
  logic [LINES-1:0] lowest_svc;
  always_comb begin
    logic seen;
    seen = 1'b0;
    lowest_svc = '0;
    for (int i = 0; i < LINES; i++) begin
      if (isr[i] && !seen) begin
        lowest_svc[i] = 1'b1;
        seen = 1'b1;
      end
    end
  end

  always_comb begin
    eoi_clr = '0;
    if (is_eoi_op) begin
      if (wr_data[7:5] == 3'b001)
        eoi_clr = lowest_svc;
      else if (wr_data[7:5] == 3'b011)
        eoi_clr[wr_data[IDXW-1:0]] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= INIT_IDLE;
      mask_q   <= '0;
      base_q   <= '0;
      rb_sel_q <= RB_PEND;
    end else begin
      if (is_init) begin
        state_q <= INIT_BASE;
      end else if (data_wr) begin
        case (state_q)
          INIT_BASE: begin
            base_q  <= {wr_data[DW-1:IDXW], {IDXW{1'b0}}};
            state_q <= INIT_TAIL;
          end
          INIT_TAIL: state_q <= INIT_IDLE;
          default:   mask_q  <= wr_data;
        endcase
      end
      if (is_sel_op) begin
        if (wr_data[1:0] == 2'b10)
          rb_sel_q <= RB_PEND;
        else if (wr_data[1:0] == 2'b11)
          rb_sel_q <= RB_SVC;
      end
    end
  end

  // R2: an initialisation command always lands in the base-wait state
  a_r2_init_starts: assert property (@(posedge clk) disable iff (rst)
    is_init |=> (state_q == INIT_BASE));

  // R4: mask moves only on an idle-state data write
  a_r4_mask_guarded: assert property (@(posedge clk) disable iff (rst)
    !(data_wr && state_q == INIT_IDLE && !is_init) |=> $stable(mask_q));
endmodule

// File: rtl/irq_req_regs.sv
module irq_req_regs #(
  parameter int LINES = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] irq_in,
  input  logic [LINES-1:0] mask,
  input  logic [LINES-1:0] ack_set,
  input  logic [LINES-1:0] eoi_clr,
  output logic [LINES-1:0] irr_q,
  output logic [LINES-1:0] isr_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      irr_q <= '0;
      isr_q <= '0;
    end else begin
      irr_q <= (irr_q & ~ack_set) | (irq_in & ~mask);
      isr_q <= (isr_q & ~eoi_clr) | ack_set;
    end
  end

  for (genvar g = 0; g < LINES; g++) begin : g_line_chk
    // R5: a masked pulse never enters the pending set
    a_r5_masked_dropped: assert property (@(posedge clk) disable iff (rst)
      (irq_in[g] && mask[g] && !irr_q[g]) |=> !irr_q[g]);
  end

  // R9: an accepted acknowledge lands in the in-service set
  a_r9_ack_to_svc: assert property (@(posedge clk) disable iff (rst)
    (|ack_set) |=> ((isr_q & $past(ack_set)) == $past(ack_set)));

  // R11: a release without a concurrent acknowledge clears its bits
  a_r11_release_clears: assert property (@(posedge clk) disable iff (rst)
    ((|eoi_clr) && !(|ack_set)) |=> ((isr_q & $past(eoi_clr)) == '0));
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int LINES = 8,
  localparam int IDXW = $clog2(LINES)
) (
  input  logic [LINES-1:0] irr,
  input  logic [LINES-1:0] isr,
  output logic             found,
  output logic [IDXW-1:0]  win_idx
);
  always_comb begin
    logic stop;
    stop    = 1'b0;
    found   = 1'b0;
    win_idx = '0;
    for (int i = 0; i < LINES; i++) begin
      if (!stop) begin
        if (isr[i]) begin
          stop = 1'b1;
        end else if (irr[i]) begin
          stop    = 1'b1;
          found   = 1'b1;
          win_idx = IDXW'(i);
        end
      end
    end
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
#(
  parameter int LINES = 8,
  parameter int DW    = 8,
  localparam int IDXW = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic             addr,
  input  logic [DW-1:0]    wr_data,
  output logic [DW-1:0]    rd_data,
  input  logic [LINES-1:0] irq_in,
  input  logic             ack_valid,
  input  logic [DW-1:0]    ack_vec,
  output logic             int_req,
  output logic [DW-1:0]    int_vec
);
  logic [DW-1:0]    mask_q, base_q;
  readback_t        rb_sel;
  logic [LINES-1:0] eoi_clr, irr, isr, ack_set;
  logic             found;
  logic [IDXW-1:0]  win_idx;

  irq_cmd_decode #(.LINES(LINES), .DW(DW)) u_dec (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .isr(isr), .mask_q(mask_q), .base_q(base_q), .rb_sel_q(rb_sel),
    .eoi_clr(eoi_clr)
  );

  irq_req_regs #(.LINES(LINES)) u_regs (
    .clk(clk), .rst(rst), .irq_in(irq_in), .mask(mask_q[LINES-1:0]),
    .ack_set(ack_set), .eoi_clr(eoi_clr), .irr_q(irr), .isr_q(isr)
  );

  irq_arbiter #(.LINES(LINES)) u_arb (
    .irr(irr), .isr(isr), .found(found), .win_idx(win_idx)
  );

  // acknowledge window: base .. base+LINES-1
  logic [DW-1:0] ack_off;
  logic          ack_ok;
  assign ack_off = ack_vec - base_q;
  assign ack_ok  = ack_valid && (ack_off < DW'(LINES));

  always_comb begin
    ack_set = '0;
    if (ack_ok) ack_set[ack_off[IDXW-1:0]] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      int_req <= 1'b0;
      int_vec <= '0;
      rd_data <= '0;
    end else begin
      int_req <= found && !ack_ok;
      int_vec <= base_q | DW'(win_idx);
      if (rd_en) begin
        if (addr)
          rd_data <= mask_q;
        else if (rb_sel == RB_SVC)
          rd_data <= DW'(isr);
        else
          rd_data <= DW'(irr);
      end
    end
  end

  // R9: the request output drops right after an accepted acknowledge
  a_r9_drop_on_ack: assert property (@(posedge clk) disable iff (rst)
    ack_ok |=> !int_req);
endmodule

// File: tb/irq_prio_ctrl_bench.sv
module irq_prio_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0, rd_en = 1'b0, addr = 1'b0;
  logic [7:0] wr_data = '0, rd_data, irq_in = '0, ack_vec = '0, int_vec;
  logic       ack_valid = 1'b0, int_req;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  irq_prio_ctrl u_irq_prio_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .irq_in(irq_in),
    .ack_valid(ack_valid), .ack_vec(ack_vec), .int_req(int_req),
    .int_vec(int_vec)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rd_data;
  endtask

  task automatic pulse(input logic [7:0] lines);
    @(negedge clk); irq_in = lines;
    @(negedge clk); irq_in = '0;
  endtask

  task automatic ack(input logic [7:0] v);
    @(negedge clk); ack_valid = 1'b1; ack_vec = v;
    @(negedge clk); ack_valid = 1'b0;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check("R1 int_req", {7'd0, int_req}, 8'h00);
    rd(1'b0, d); check("R1 pending", d, 8'h00);
    rd(1'b1, d); check("R1 mask", d, 8'h00);
  endtask

  task automatic t_init();
    logic [7:0] d;
    wr(1'b0, 8'h13); wr(1'b1, 8'h47); wr(1'b1, 8'h01);
    rd(1'b1, d); check("R2 mask untouched", d, 8'h00);
    wr(1'b1, 8'hF0);
    rd(1'b1, d); check("R4 mask", d, 8'hF0);
    repeat (3) @(negedge clk);
    check("R14 hold", rd_data, 8'hF0);
  endtask

  task automatic t_masked();
    logic [7:0] d;
    pulse(8'h20); settle();
    rd(1'b0, d); check("R5 dropped", d, 8'h00);
    check("R5 no int", {7'd0, int_req}, 8'h00);
    wr(1'b1, 8'h00); settle();
    rd(1'b0, d); check("R5 not deferred", d, 8'h00);
    check("R5 no int later", {7'd0, int_req}, 8'h00);
  endtask

  task automatic t_priority();
    logic [7:0] d;
    pulse(8'h28); settle();
    rd(1'b0, d); check("R6 pending", d, 8'h28);
    check("R7 int", {7'd0, int_req}, 8'h01);
    check("R7 R3 vec", int_vec, 8'h43);
  endtask

  task automatic t_ack_block();
    logic [7:0] d;
    ack(8'h43);
    check("R9 drop", {7'd0, int_req}, 8'h00);
    settle();
    check("R8 blocked", {7'd0, int_req}, 8'h00);
    wr(1'b0, 8'h0B);
    rd(1'b0, d); check("R12 R9 svc", d, 8'h08);
    wr(1'b0, 8'h0A);
    rd(1'b0, d); check("R9 pend cleared", d, 8'h20);
  endtask

  task automatic t_nested_eoi();
    logic [7:0] d;
    pulse(8'h02); settle();
    check("R8 nest int", {7'd0, int_req}, 8'h01);
    check("R8 nest vec", int_vec, 8'h41);
    ack(8'h41);
    wr(1'b0, 8'h0B);
    rd(1'b0, d); check("R9 svc two", d, 8'h0A);
    wr(1'b0, 8'h20);
    rd(1'b0, d); check("R10 lowest", d, 8'h08);
    settle();
    check("R10 still blocked", {7'd0, int_req}, 8'h00);
    wr(1'b0, 8'h08);
    rd(1'b0, d); check("R12 keep", d, 8'h08);
  endtask

  task automatic t_specific();
    logic [7:0] d;
    wr(1'b0, 8'h40);
    rd(1'b0, d); check("R11 unused op", d, 8'h08);
    wr(1'b0, 8'h63);
    rd(1'b0, d); check("R11 specific", d, 8'h00);
    settle();
    check("R11 int", {7'd0, int_req}, 8'h01);
    check("R11 vec", int_vec, 8'h45);
  endtask

  task automatic t_range();
    logic [7:0] d;
    ack(8'h55); ack(8'h3F); settle();
    check("R9 out of range", {7'd0, int_req}, 8'h01);
    wr(1'b0, 8'h0A);
    rd(1'b0, d); check("R9 pend kept", d, 8'h20);
  endtask

  task automatic t_late_mask();
    ack(8'h45);
    pulse(8'h40); settle();
    check("R8 lower blocked", {7'd0, int_req}, 8'h00);
    wr(1'b1, 8'hFF);
    wr(1'b0, 8'h65); settle();
    check("R13 int", {7'd0, int_req}, 8'h01);
    check("R13 vec", int_vec, 8'h46);
  endtask

  task automatic t_rebase();
    logic [7:0] d;
    wr(1'b0, 8'h13); wr(1'b1, 8'h8D); wr(1'b1, 8'h01); settle();
    check("R3 new base", int_vec, 8'h8E);
    rd(1'b1, d); check("R2 mask kept", d, 8'hFF);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_init();
    t_masked();
    t_priority();
    t_ack_block();
    t_nested_eoi();
    t_specific();
    t_range();
    t_late_mask();
    t_rebase();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule